// File: doc/BRIEF.md
# Dual-Mode Serial Control Word Receiver

This block is the slave side of a configuration port. A host writes 16-bit control words to it over one of two serial buses, chosen by a strap pin: a two-wire bus with start and stop conditions, a device address and acknowledge bits, or a three-wire bus in which a select line frames each word. The block does not clock anything from the bus lines. It oversamples clock, data and select through synchronizers running on a fast system clock and finds the edges from those samples.

Each accepted word carries a 7-bit register index in its upper bits and a 9-bit value in its lower bits. The value is written into a small register file whose contents appear as one flat parallel output. Two pairs of registers are linked: the left and right input volumes, and the left and right headphone volumes. A write to either register of a pair with its top data bit set loads both registers. Each headphone volume also drives a mute flag that goes high when the volume code is below a fixed threshold. Writing a reserved index returns the whole file to its power-on values.

Top module: `ctrl_word_rx`

## Requirements
- R1: With `mode_3w` low only two-wire traffic is decoded. With it high only three-wire traffic is decoded. Traffic in the protocol that is not selected writes nothing, and in three-wire mode `sda_pull_o` stays low.
- R2: A word is sent MSB first. Word bits 15:9 are the register index and bits 8:0 are the data. Index a lands in `regs_o[9*a+8 : 9*a]`.
- R3: The two-wire device address is 0011010 when `addr_sel` is low and 0011011 when it is high. For a matching address with the write bit (0), and for each of the two bytes after it, `sda_pull_o` is high during the ninth clock.
- R4: If the address byte does not match, or has the read bit (1) set, no acknowledge is given and nothing is written until the next start condition.
- R5: A two-wire write is the address byte, then {index, data bit 8}, then data bits 7:0. The word is committed after the third byte. Any further bytes before the stop get no acknowledge and write nothing.
- R6: In three-wire mode a bit is shifted in on each rising clock edge while `cs_in` is low. The rising edge of `cs_in` commits the word only if exactly 16 bits were shifted. Any other count, including 15 and 17, discards the word.
- R7: A write to index 0 or 1 with data bit 8 set stores the same 9-bit value in both index 0 and index 1. With bit 8 clear, only the addressed register changes.
- R8: A write to index 2 or 3 with data bit 8 set stores the same 9-bit value in both index 2 and index 3.
- R9: `hp_mute_l_o` is high exactly when bits 6:0 of index 2 are below 0110000 (48). `hp_mute_r_o` does the same for index 3.
- R10: A write to index 15, with any data, sets every register to its default: indices 0 and 1 to 0x097, indices 2 and 3 to 0x079, and all others to 0.
- R11: Writes to indices from NUM_REGS to 14, and above 15, change no register.
- R12: After reset the registers hold the R10 defaults and `sda_pull_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_3w | input | 1 | Bus select: 0 two-wire, 1 three-wire |
| addr_sel | input | 1 | Low bit of the two-wire device address |
| scl_in | input | 1 | Serial clock line (both modes) |
| sda_in | input | 1 | Serial data line as seen on the wire (both modes) |
| cs_in | input | 1 | Three-wire select; its rising edge commits the word |
| sda_pull_o | output | 1 | Pulls the data line low to acknowledge (open drain) |
| regs_o | output | NUM_REGS*9 | All registers, index a at bits 9*a+8 : 9*a |
| hp_mute_l_o | output | 1 | Left headphone volume is below the mute threshold |
| hp_mute_r_o | output | 1 | Right headphone volume is below the mute threshold |

## Verification
On every cycle the assertions check the following. A linked write leaves both registers of the pair equal. The reserved index restores the defaults. An out-of-range index leaves the file unchanged, and the file changes only on a committed word. The acknowledge line stays quiet in three-wire mode. Decoding itself is shown only by the bench's bus scenarios: address matching, the read bit, acknowledge timing inside the ninth clock, extra bytes, wrong three-wire bit counts and traffic in the unselected protocol. Each of these depends on a whole frame of serial stimulus.

// File: rtl/ctrl_rx_pkg.sv
package ctrl_rx_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 9;
    localparam int WORD_W = ADDR_W + DATA_W;

    // register indices with behaviour of their own
    localparam logic [ADDR_W-1:0] IDX_IN_L   = 7'd0;
    localparam logic [ADDR_W-1:0] IDX_IN_R   = 7'd1;
    localparam logic [ADDR_W-1:0] IDX_HP_L   = 7'd2;
    localparam logic [ADDR_W-1:0] IDX_HP_R   = 7'd3;
    localparam logic [ADDR_W-1:0] IDX_REINIT = 7'd15;

    localparam logic [ADDR_W-2:0] DEV_ADDR_HI  = 6'b001101;
    localparam logic [6:0]        HP_MUTE_BELOW = 7'd48;

    localparam logic [DATA_W-1:0] DEF_IN_VOL = 9'h097;
    localparam logic [DATA_W-1:0] DEF_HP_VOL = 9'h079;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ctrl_word_t;

    typedef enum logic [2:0] {
        TW_IDLE, TW_DEV, TW_ACK_DEV, TW_B1, TW_ACK_B1, TW_B2, TW_ACK_B2, TW_SKIP
    } tw_state_e;

    function automatic logic [DATA_W-1:0] reg_default(input int idx);
        case (idx)
            0, 1:    return DEF_IN_VOL;
            2, 3:    return DEF_HP_VOL;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/ctrl_line_sync.sv
module ctrl_line_sync #(
    parameter int N_LINES = 3,
    parameter int STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] raw_i,
    output logic [N_LINES-1:0] cur_o,
    output logic [N_LINES-1:0] prev_o
);

    typedef struct packed {
        logic [STAGES-1:0][N_LINES-1:0] stg;
        logic [N_LINES-1:0]             prev;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d        = q;
        d.stg[0] = raw_i;
        for (int s = 1; s < STAGES; s++) begin
            d.stg[s] = q.stg[s-1];
        end
        d.prev = q.stg[STAGES-1];
    end

    // idle lines rest high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign cur_o  = q.stg[STAGES-1];
    assign prev_o = q.prev;

endmodule

// File: rtl/ctrl_twowire_rx.sv
module ctrl_twowire_rx
    import ctrl_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       addr_sel_i,
    input  logic       scl_cur_i,
    input  logic       scl_prev_i,
    input  logic       sda_cur_i,
    input  logic       sda_prev_i,
    output logic       ack_o,
    output logic       word_valid_o,
    output ctrl_word_t word_o
);

    localparam logic [3:0] BYTE_BITS = 4'd8;

    typedef struct packed {
        tw_state_e  state;
        logic [3:0] cnt;
        logic [7:0] shreg;
        logic [7:0] hi;
        logic       ack;
        logic       valid;
        ctrl_word_t word;
    } tw_t;

    tw_t d, q;

    logic       scl_rise, scl_fall, start_cond, stop_cond;
    logic [7:0] dev_write;

    assign scl_rise   = scl_cur_i & ~scl_prev_i;
    assign scl_fall   = ~scl_cur_i & scl_prev_i;
    assign start_cond = scl_cur_i & scl_prev_i & sda_prev_i & ~sda_cur_i;
    assign stop_cond  = scl_cur_i & scl_prev_i & ~sda_prev_i & sda_cur_i;
    assign dev_write  = {DEV_ADDR_HI, addr_sel_i, 1'b0};

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (!enable_i) begin
            d = '0;
        end else if (start_cond) begin
            d.state = TW_DEV;
            d.cnt   = '0;
            d.ack   = 1'b0;
        end else if (stop_cond) begin
            d.state = TW_IDLE;
            d.ack   = 1'b0;
        end else begin
            case (q.state)
                TW_DEV, TW_B1, TW_B2: begin
                    if (scl_rise) begin
                        d.shreg = {q.shreg[6:0], sda_cur_i};
                        d.cnt   = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == BYTE_BITS) begin
                        case (q.state)
                            TW_DEV: begin
                                if (q.shreg == dev_write) begin
                                    d.ack   = 1'b1;
                                    d.state = TW_ACK_DEV;
                                end else begin
                                    d.state = TW_SKIP;
                                end
                            end
                            TW_B1: begin
                                d.hi    = q.shreg;
                                d.ack   = 1'b1;
                                d.state = TW_ACK_B1;
                            end
                            default: begin
                                d.ack   = 1'b1;
                                d.valid = 1'b1;
                                d.word  = {q.hi, q.shreg};
                                d.state = TW_ACK_B2;
                            end
                        endcase
                    end
                end
                TW_ACK_DEV, TW_ACK_B1, TW_ACK_B2: begin
                    if (scl_fall) begin
                        d.ack = 1'b0;
                        d.cnt = '0;
                        case (q.state)
                            TW_ACK_DEV: d.state = TW_B1;
                            TW_ACK_B1:  d.state = TW_B2;
                            default:    d.state = TW_SKIP;
                        endcase
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ack_o        = q.ack;
    assign word_valid_o = q.valid;
    assign word_o       = q.word;

endmodule

// File: rtl/ctrl_threewire_rx.sv
module ctrl_threewire_rx
    import ctrl_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       clk_cur_i,
    input  logic       clk_prev_i,
    input  logic       dat_cur_i,
    input  logic       sel_cur_i,
    input  logic       sel_prev_i,
    output logic       word_valid_o,
    output ctrl_word_t word_o
);

    localparam int               CNT_W    = $clog2(WORD_W) + 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic              valid;
        ctrl_word_t        word;
    } tr_t;

    tr_t  d, q;
    logic sel_rise, clk_rise;

    assign sel_rise = sel_cur_i & ~sel_prev_i;
    assign clk_rise = clk_cur_i & ~clk_prev_i;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (!enable_i) begin
            d = '0;
        end else if (sel_rise) begin
            if (q.cnt == FULL_CNT) begin
                d.valid = 1'b1;
                d.word  = q.shreg;
            end
            d.cnt = '0;
        end else if (!sel_cur_i && clk_rise) begin
            d.shreg = {q.shreg[WORD_W-2:0], dat_cur_i};
            if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign word_valid_o = q.valid;
    assign word_o       = q.word;

endmodule

// File: rtl/ctrl_regfile.sv
module ctrl_regfile
    import ctrl_rx_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid_i,
    input  ctrl_word_t                    wr_word_i,
    output logic [NUM_REGS*DATA_W-1:0]    regs_o,
    output logic                          hp_mute_l_o,
    output logic                          hp_mute_r_o
);

    typedef logic [NUM_REGS-1:0][DATA_W-1:0] file_t;

    file_t             d, q;
    logic              linked;
    logic [ADDR_W-1:0] partner;

    function automatic file_t defaults();
        file_t f;
        for (int i = 0; i < NUM_REGS; i++) f[i] = reg_default(i);
        return f;
    endfunction

    // pairs differ only in the low index bit
    assign linked  = wr_word_i.data[DATA_W-1] &&
                     (wr_word_i.addr == IDX_IN_L || wr_word_i.addr == IDX_IN_R ||
                      wr_word_i.addr == IDX_HP_L || wr_word_i.addr == IDX_HP_R);
    assign partner = {wr_word_i.addr[ADDR_W-1:1], ~wr_word_i.addr[0]};

    always_comb begin
        d = q;
        if (wr_valid_i) begin
            if (wr_word_i.addr == IDX_REINIT) begin
                d = defaults();
            end else begin
                for (int i = 0; i < NUM_REGS; i++) begin
                    if (wr_word_i.addr == ADDR_W'(i) || (linked && partner == ADDR_W'(i)))
                        d[i] = wr_word_i.data;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= defaults();
        else        q <= d;
    end

    assign regs_o      = q;
    assign hp_mute_l_o = q[IDX_HP_L][6:0] < HP_MUTE_BELOW;
    assign hp_mute_r_o = q[IDX_HP_R][6:0] < HP_MUTE_BELOW;

endmodule

// File: rtl/ctrl_word_rx.sv
module ctrl_word_rx
    import ctrl_rx_pkg::*;
#(
    parameter int NUM_REGS    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_3w,
    input  logic                       addr_sel,
    input  logic                       scl_in,
    input  logic                       sda_in,
    input  logic                       cs_in,
    output logic                       sda_pull_o,
    output logic [NUM_REGS*DATA_W-1:0] regs_o,
    output logic                       hp_mute_l_o,
    output logic                       hp_mute_r_o
);

    localparam int L_SCL = 0;
    localparam int L_SDA = 1;
    localparam int L_CS  = 2;

    logic [2:0]  line_cur, line_prev;
    logic        tw_valid, tr_valid, wr_valid;
    ctrl_word_t  tw_word, tr_word, wr_word;

    ctrl_line_sync #(.N_LINES(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({cs_in, sda_in, scl_in}),
        .cur_o  (line_cur),
        .prev_o (line_prev)
    );

    ctrl_twowire_rx u_tw (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (~mode_3w),
        .addr_sel_i   (addr_sel),
        .scl_cur_i    (line_cur[L_SCL]),
        .scl_prev_i   (line_prev[L_SCL]),
        .sda_cur_i    (line_cur[L_SDA]),
        .sda_prev_i   (line_prev[L_SDA]),
        .ack_o        (sda_pull_o),
        .word_valid_o (tw_valid),
        .word_o       (tw_word)
    );

    ctrl_threewire_rx u_tr (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (mode_3w),
        .clk_cur_i    (line_cur[L_SCL]),
        .clk_prev_i   (line_prev[L_SCL]),
        .dat_cur_i    (line_cur[L_SDA]),
        .sel_cur_i    (line_cur[L_CS]),
        .sel_prev_i   (line_prev[L_CS]),
        .word_valid_o (tr_valid),
        .word_o       (tr_word)
    );

    assign wr_valid = mode_3w ? tr_valid : tw_valid;
    assign wr_word  = mode_3w ? tr_word  : tw_word;

    ctrl_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_valid_i  (wr_valid),
        .wr_word_i   (wr_word),
        .regs_o      (regs_o),
        .hp_mute_l_o (hp_mute_l_o),
        .hp_mute_r_o (hp_mute_r_o)
    );

endmodule

// File: rtl/ctrl_word_rx_chk.sv
module ctrl_word_rx_chk
    import ctrl_rx_pkg::*;
#(
    parameter int NUM_REGS = 10
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mode_3w,
    input logic                       sda_pull_o,
    input logic                       wr_valid,
    input ctrl_word_t                 wr_word,
    input logic [NUM_REGS*DATA_W-1:0] regs_o
);

    function automatic logic [NUM_REGS*DATA_W-1:0] default_vec();
        logic [NUM_REGS*DATA_W-1:0] v;
        for (int i = 0; i < NUM_REGS; i++) v[i*DATA_W +: DATA_W] = reg_default(i);
        return v;
    endfunction

    localparam logic [ADDR_W-1:0] N_IDX = ADDR_W'(NUM_REGS);

    logic [DATA_W-1:0] in_l, in_r, hp_l, hp_r;
    assign in_l = regs_o[0*DATA_W +: DATA_W];
    assign in_r = regs_o[1*DATA_W +: DATA_W];
    assign hp_l = regs_o[2*DATA_W +: DATA_W];
    assign hp_r = regs_o[3*DATA_W +: DATA_W];

    assert_no_ack_threewire_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_3w && $past(mode_3w) |-> !sda_pull_o);

    assert_only_words_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> $stable(regs_o));

    assert_input_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_word.addr == IDX_IN_L || wr_word.addr == IDX_IN_R) && wr_word.data[8]
        |=> in_l == in_r);

    assert_hp_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && (wr_word.addr == IDX_HP_L || wr_word.addr == IDX_HP_R) && wr_word.data[8]
        |=> hp_l == hp_r);

    assert_reinit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_word.addr == IDX_REINIT |=> regs_o == default_vec());

    assert_ignored_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_word.addr >= N_IDX && wr_word.addr != IDX_REINIT |=> $stable(regs_o));

endmodule

bind ctrl_word_rx ctrl_word_rx_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_3w    (mode_3w),
    .sda_pull_o (sda_pull_o),
    .wr_valid   (wr_valid),
    .wr_word    (wr_word),
    .regs_o     (regs_o)
);

// File: tb/ctrl_word_rx_tb.sv
module ctrl_word_rx_tb;

    localparam int NREG = 10;
    localparam int H    = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_3w = 1'b0, addr_sel = 1'b0;
    logic scl = 1'b1, sda_tb = 1'b1, cs = 1'b1;
    logic sda_line, sda_pull, mute_l, mute_r;
    logic [NREG*9-1:0] regs;

    int checks = 0, fails = 0;
    logic [8:0] exp_r [NREG];

    always #2.5 clk = ~clk;

    assign sda_line = sda_tb & ~sda_pull;

    ctrl_word_rx #(.NUM_REGS(NREG)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w), .addr_sel(addr_sel),
        .scl_in(scl), .sda_in(sda_line), .cs_in(cs),
        .sda_pull_o(sda_pull), .regs_o(regs),
        .hp_mute_l_o(mute_l), .hp_mute_r_o(mute_r)
    );

    task automatic hw(input int n = H);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_defaults();
        for (int i = 0; i < NREG; i++) exp_r[i] = 9'h000;
        exp_r[0] = 9'h097; exp_r[1] = 9'h097;
        exp_r[2] = 9'h079; exp_r[3] = 9'h079;
    endtask

    task automatic chk_regs(input string tag);
        for (int i = 0; i < NREG; i++) chk(tag, 32'(regs[i*9 +: 9]), 32'(exp_r[i]));
    endtask

    task automatic tw_start();
        sda_tb = 1'b1; scl = 1'b1; hw();
        sda_tb = 1'b0; hw();
        scl = 1'b0; hw();
    endtask

    task automatic tw_stop();
        sda_tb = 1'b0; hw();
        scl = 1'b1; hw();
        sda_tb = 1'b1; hw();
    endtask

    task automatic tw_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_tb = b[i]; hw();
            scl = 1'b1; hw();
            scl = 1'b0; hw();
        end
        sda_tb = 1'b1; hw();
        scl = 1'b1; hw(H/2);
        acked = ~sda_line;
        hw(H/2);
        scl = 1'b0; hw();
    endtask

    task automatic tw_frame(input logic [6:0] dev, input logic rw, input logic [6:0] a,
                            input logic [8:0] v, output logic [2:0] acks);
        tw_start();
        tw_byte({dev, rw}, acks[2]);
        tw_byte({a, v[8]}, acks[1]);
        tw_byte(v[7:0], acks[0]);
        tw_stop();
        hw(10);
    endtask

    task automatic tr_frame(input logic [31:0] bits, input int n);
        scl = 1'b0; hw();
        cs = 1'b0; hw();
        for (int i = n - 1; i >= 0; i--) begin
            sda_tb = bits[i]; hw();
            scl = 1'b1; hw();
            scl = 1'b0; hw();
        end
        hw();
        cs = 1'b1; hw();
        sda_tb = 1'b1; hw();
        scl = 1'b1; hw(10);
    endtask

    task automatic t_reset();
        model_defaults();
        chk("R12 ack idle", 32'(sda_pull), 0);
        chk_regs("R12 reset values");
        chk("R9 default left mute", 32'(mute_l), 0);
        chk("R9 default right mute", 32'(mute_r), 0);
    endtask

    task automatic t_basic_write();
        logic [2:0] a;
        tw_frame(7'b0011010, 1'b0, 7'd5, 9'h1A5, a);
        chk("R3 acks on match", 32'(a), 32'b111);
        exp_r[5] = 9'h1A5;
        chk_regs("R2 R5 basic write");
    endtask

    task automatic t_addr_select();
        logic [2:0] a;
        addr_sel = 1'b1; hw();
        tw_frame(7'b0011010, 1'b0, 7'd6, 9'h0FF, a);
        chk("R4 wrong device no ack", 32'(a), 0);
        chk_regs("R4 wrong device no write");
        tw_frame(7'b0011011, 1'b0, 7'd6, 9'h0C3, a);
        chk("R3 alternate address acks", 32'(a), 32'b111);
        exp_r[6] = 9'h0C3;
        chk_regs("R3 alternate address write");
        addr_sel = 1'b0; hw();
    endtask

    task automatic t_read_bit();
        logic [2:0] a;
        tw_frame(7'b0011010, 1'b1, 7'd4, 9'h111, a);
        chk("R4 read bit no ack", 32'(a), 0);
        chk_regs("R4 read bit no write");
    endtask

    task automatic t_link_input();
        logic [2:0] a;
        tw_frame(7'b0011010, 1'b0, 7'd0, 9'h125, a);
        exp_r[0] = 9'h125; exp_r[1] = 9'h125;
        chk_regs("R7 linked input write");
        tw_frame(7'b0011010, 1'b0, 7'd1, 9'h033, a);
        exp_r[1] = 9'h033;
        chk_regs("R7 unlinked right only");
    endtask

    task automatic t_link_hp();
        logic [2:0] a;
        tw_frame(7'b0011010, 1'b0, 7'd3, 9'h12F, a);
        exp_r[2] = 9'h12F; exp_r[3] = 9'h12F;
        chk_regs("R8 linked headphone write");
        chk("R9 left muted at 47", 32'(mute_l), 1);
        chk("R9 right muted at 47", 32'(mute_r), 1);
        tw_frame(7'b0011010, 1'b0, 7'd3, 9'h030, a);
        exp_r[3] = 9'h030;
        chk_regs("R8 unlinked headphone");
        chk("R9 right unmuted at 48", 32'(mute_r), 0);
        chk("R9 left still muted", 32'(mute_l), 1);
    endtask

    task automatic t_ignored_index();
        logic [2:0] a;
        tw_frame(7'b0011010, 1'b0, 7'd12, 9'h1FF, a);
        chk_regs("R11 index 12 ignored");
        tw_frame(7'b0011010, 1'b0, 7'd90, 9'h155, a);
        chk_regs("R11 index 90 ignored");
    endtask

    task automatic t_extra_byte();
        logic a0, a1, a2, a3;
        tw_start();
        tw_byte({7'b0011010, 1'b0}, a0);
        tw_byte({7'd7, 1'b0}, a1);
        tw_byte(8'h5A, a2);
        tw_byte(8'hFF, a3);
        tw_stop(); hw(10);
        chk("R5 first three acked", 32'({a0, a1, a2}), 32'b111);
        chk("R5 fourth byte not acked", 32'(a3), 0);
        exp_r[7] = 9'h05A;
        chk_regs("R5 extra byte ignored");
    endtask

    task automatic t_threewire();
        logic [2:0] a;
        mode_3w = 1'b1; hw();
        tr_frame({16'b0, 7'd6, 9'h0AB}, 16);
        exp_r[6] = 9'h0AB;
        chk_regs("R6 sixteen bit word");
        tr_frame({17'b0, 6'd4, 9'h1EE}, 15);
        chk_regs("R6 fifteen bits discarded");
        tr_frame({15'b0, 8'd4, 9'h1EE}, 17);
        chk_regs("R6 seventeen bits discarded");
        tw_frame(7'b0011010, 1'b0, 7'd8, 9'h155, a);
        chk("R1 no ack in three-wire mode", 32'(a), 0);
        chk_regs("R1 two-wire ignored in three-wire mode");
        mode_3w = 1'b0; hw();
        tr_frame({16'b0, 7'd8, 9'h0AA}, 16);
        chk_regs("R1 three-wire ignored in two-wire mode");
    endtask

    task automatic t_reinit();
        logic [2:0] a;
        tw_frame(7'b0011010, 1'b0, 7'd15, 9'h1B3, a);
        model_defaults();
        chk_regs("R10 reinit to defaults");
        chk("R10 left mute after reinit", 32'(mute_l), 0);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        hw(10);
        rst_n = 1'b1;
        hw(10);
        t_reset();
        t_basic_write();
        t_addr_select();
        t_read_bit();
        t_link_input();
        t_link_hp();
        t_ignored_index();
        t_extra_byte();
        t_threewire();
        t_reinit();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule